// File: doc/BRIEF.md
# Per-Channel Blocking Strobe Generator

This block drives two channel blocking strobes, one for the receive path and one for the transmit path of a framed serial stream with up to 32 timeslots. Each strobe rises for the whole time of every channel whose mask bit is set and stays low for every other channel. Downstream logic uses the strobe to pick out or gate selected channels.

Each direction has its own 32-bit mask, stored as four byte registers on a simple register bus. Each direction also has its own bit-rate enable and frame sync. A position counter per direction starts at each frame sync and then runs freely from one frame to the next. A rate select picks a 256-bit frame of 32 channels or a 193-bit frame made of one framing slot and 24 channels. Mask and rate changes are held until the next frame boundary, so a strobe never changes in the middle of a channel.

Top module: `chanBlockGen`

## Requirements
- R1: Mask bit b of byte register k (k = 0..3) controls channel 8k+b+1. The receive bytes k = 0..3 are at addresses 0x2B..0x2E and the transmit bytes at 0x22..0x25.
- R2: All eight mask registers reset to zero. Each one returns on `regRdData` the last byte written to it, combinationally from `regAddr`. Any other address reads zero.
- R3: When `sysRate`=0, a frame is 256 bit times. Channel n covers bit times 8(n-1) to 8n-1, counted from 0 at the first bit after the bit time that carried the frame sync. The strobe equals that channel's mask bit for all eight bit times.
- R4: When `sysRate`=1, a frame is 193 bit times. Bit time 0 is a framing slot with the strobe low. Channel n (1..24) covers bit times 8(n-1)+1 to 8n.
- R5: When `sysRate`=1, the strobe never rises for channels 25..32. The fourth mask byte of either direction has no effect, but it is still stored and read back.
- R6: A mask write takes effect at the next frame boundary, and a strobe changes only in a clock cycle that follows an active bit enable.
- R7: After reset, a direction's strobe stays low until that direction sees its first frame sync.
- R8: Without a new sync, the counter wraps at the end of each frame and the pattern repeats. A sync in the middle of a frame restarts the frame at the next bit time.
- R9: `sysRate` is sampled only at a frame boundary. A change in the middle of a frame leaves the length of the current frame unchanged.
- R10: The two directions have separate position tracking. The bit enable and frame sync of one direction have no effect on the strobe of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysRate | input | 1 | 0: 32-channel frame, 1: 24-channel frame with framing slot |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| rxBitEn | input | 1 | Receive bit-time enable, one clock per bit |
| rxFrameSync | input | 1 | Receive frame sync, valid with `rxBitEn` |
| txBitEn | input | 1 | Transmit bit-time enable |
| txFrameSync | input | 1 | Transmit frame sync, valid with `txBitEn` |
| rxBlock | output | 1 | Receive channel blocking strobe |
| txBlock | output | 1 | Transmit channel blocking strobe |

## Verification
The bench compares every bit time of every frame against its own model. A wrong byte-to-channel mapping, or an off-by-one at the framing slot in 193-bit mode, would therefore show up as a strobe that is one bit or one channel early. Mask writes made in the middle of a frame must not appear before the wrap; a design that loads masks directly would raise the strobe at once. Further tests set the fourth byte in 24-channel mode, change the rate in the middle of a frame, resynchronise in the middle of a frame, and sync only one direction. These catch a design that blocks the upper channels too late, changes frame length at once, ignores a new sync, or shares one counter between the two directions.

// File: rtl/chanblk_pkg.sv
package chanblk_pkg;
  localparam int NUM_CH    = 32;
  localparam int CH_BITS   = 8;
  localparam int NUM_DIR   = 2;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int BYTES     = NUM_CH / DATA_W;
  localparam int BYTE_W    = $clog2(BYTES);
  localparam int POS_W     = $clog2(NUM_CH * CH_BITS);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int FULL_LAST = NUM_CH * CH_BITS - 1;
  localparam int T1_CH     = 24;
  localparam int T1_LAST   = T1_CH * CH_BITS;
  localparam logic [ADDR_W-1:0] RX_BASE = 8'h2B;
  localparam logic [ADDR_W-1:0] TX_BASE = 8'h22;

  typedef struct packed {
    logic            load;
    logic            valid;
    logic            fSlot;
    logic            rate;
    logic [CH_W-1:0] chan;
  } blkStrobe_t;

  function automatic logic [ADDR_W-1:0] dirBase(input int d);
    return (d == 0) ? RX_BASE : TX_BASE;
  endfunction
endpackage

// File: rtl/chanBlkCtrl.sv
module chanBlkCtrl
  import chanblk_pkg::*;
#(
  parameter int DIRS = NUM_DIR
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sysRate,
  input  logic [DIRS-1:0] bitEn,
  input  logic [DIRS-1:0] frameSync,
  output blkStrobe_t      strobe [DIRS]
);
  localparam logic [POS_W-1:0] LAST_FULL = POS_W'(FULL_LAST);
  localparam logic [POS_W-1:0] LAST_T1   = POS_W'(T1_LAST);

  for (genvar d = 0; d < DIRS; d++) begin : gDir
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] slotPos;
    logic             rateQ;
    logic             validQ;
    logic             atLast;
    logic             boundary;

    // The frame ends on the last bit of the latched rate
    assign atLast   = validQ && (pos == (rateQ ? LAST_T1 : LAST_FULL));
    assign boundary = bitEn[d] && (frameSync[d] || atLast);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pos    <= '0;
        rateQ  <= 1'b0;
        validQ <= 1'b0;
      end else if (boundary) begin
        pos    <= '0;
        rateQ  <= sysRate;
        validQ <= 1'b1;
      end else if (bitEn[d] && validQ) begin
        pos <= pos + 1'b1;
      end
    end

    // The framing slot shifts the channels up by one bit in 24-channel mode
    assign slotPos = rateQ ? (pos - 1'b1) : pos;

    assign strobe[d].load  = boundary;
    assign strobe[d].valid = validQ;
    assign strobe[d].fSlot = rateQ && (pos == '0);
    assign strobe[d].rate  = rateQ;
    assign strobe[d].chan  = slotPos[POS_W-1 -: CH_W];
  end
endmodule

// File: rtl/chanBlkData.sv
module chanBlkData
  import chanblk_pkg::*;
#(
  parameter int DIRS = NUM_DIR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  blkStrobe_t        strobe [DIRS],
  output logic [DIRS-1:0]   blockOut
);
  logic [DIRS-1:0][DATA_W-1:0] rdPart;

  for (genvar d = 0; d < DIRS; d++) begin : gDir
    localparam logic [ADDR_W-1:0] BASE = dirBase(d);
    logic [ADDR_W-1:0] offs;
    logic              inRange;
    logic [NUM_CH-1:0] maskShadow;
    logic [NUM_CH-1:0] maskLive;
    logic              upperCut;

    assign offs    = regAddr - BASE;
    assign inRange = (regAddr >= BASE) && (offs < ADDR_W'(BYTES));

    // Register file: bus writes land in the shadow copy
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskShadow <= '0;
      end else if (regWr && inRange) begin
        for (int b = 0; b < BYTES; b++) begin
          if (offs[BYTE_W-1:0] == BYTE_W'(b)) maskShadow[b*DATA_W +: DATA_W] <= regWrData;
        end
      end
    end

    // The live copy follows the shadow only at a frame boundary
    always_ff @(posedge clk) begin
      if (!rstN)                maskLive <= '0;
      else if (strobe[d].load) maskLive <= maskShadow;
    end

    assign rdPart[d] = inRange ? maskShadow[offs[BYTE_W-1:0]*DATA_W +: DATA_W] : '0;

    assign upperCut    = strobe[d].rate && (strobe[d].chan >= CH_W'(T1_CH));
    assign blockOut[d] = strobe[d].valid && !strobe[d].fSlot && !upperCut
                         && maskLive[strobe[d].chan];
  end

  always_comb begin
    regRdData = '0;
    for (int d = 0; d < DIRS; d++) regRdData = regRdData | rdPart[d];
  end
endmodule

// File: rtl/chanBlockGen.sv
module chanBlockGen
  import chanblk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysRate,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxBitEn,
  input  logic              rxFrameSync,
  input  logic              txBitEn,
  input  logic              txFrameSync,
  output logic              rxBlock,
  output logic              txBlock
);
  blkStrobe_t           dirStrobe [NUM_DIR];
  logic [NUM_DIR-1:0]   blockVec;

  chanBlkCtrl #(.DIRS(NUM_DIR)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sysRate   (sysRate),
    .bitEn     ({txBitEn, rxBitEn}),
    .frameSync ({txFrameSync, rxFrameSync}),
    .strobe    (dirStrobe)
  );

  chanBlkData #(.DIRS(NUM_DIR)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (dirStrobe),
    .blockOut  (blockVec)
  );

  assign rxBlock = blockVec[0];
  assign txBlock = blockVec[1];
endmodule

// File: rtl/chanBlkChk.sv
module chanBlkChk
  import chanblk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              rxBitEn,
  input logic              rxFrameSync,
  input logic              txBitEn,
  input logic              rxBlock,
  input logic              txBlock,
  input blkStrobe_t        rxSt,
  input blkStrobe_t        txSt
);
  function automatic logic isMask(input logic [ADDR_W-1:0] a);
    return ((a >= RX_BASE) && (a < RX_BASE + ADDR_W'(BYTES)))
        || ((a >= TX_BASE) && (a < TX_BASE + ADDR_W'(BYTES)));
  endfunction

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxBitEn |=> $stable(rxBlock)); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !txBitEn |=> $stable(txBlock)); // R6
  AST_FSLOT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rxSt.fSlot |-> !rxBlock); // R4
  AST_RX_NOSYNC: assert property (@(posedge clk) disable iff (!rstN)
    !rxSt.valid |-> !rxBlock); // R7
  AST_TX_NOSYNC: assert property (@(posedge clk) disable iff (!rstN)
    !txSt.valid |-> !txBlock); // R7
  AST_T1_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rxSt.rate && rxSt.valid) |-> (rxSt.fSlot || rxSt.chan < CH_W'(T1_CH))); // R5
  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && isMask(regAddr)) |=> (regAddr != $past(regAddr) || regRdData == $past(regWrData))); // R2
  AST_RESYNC: assert property (@(posedge clk) disable iff (!rstN)
    (rxBitEn && rxFrameSync) |=> (rxSt.valid && (rxSt.fSlot || rxSt.chan == '0))); // R8
endmodule

bind chanBlockGen chanBlkChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWr       (regWr),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .rxBitEn     (rxBitEn),
  .rxFrameSync (rxFrameSync),
  .txBitEn     (txBitEn),
  .rxBlock     (rxBlock),
  .txBlock     (txBlock),
  .rxSt        (dirStrobe[0]),
  .txSt        (dirStrobe[1])
);

// File: tb/sim_chanBlockGen.sv
`timescale 1ns/1ps
module sim_chanBlockGen;
  logic clk = 1'b0;
  logic rstN, sysRate, regWr, rxBitEn, rxFrameSync, txBitEn, txFrameSync;
  logic [7:0] regAddr, regWrData, regRdData;
  logic rxBlock, txBlock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chanBlockGen u0 (
    .clk(clk), .rstN(rstN), .sysRate(sysRate), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxBitEn(rxBitEn),
    .rxFrameSync(rxFrameSync), .txBitEn(txBitEn), .txFrameSync(txFrameSync),
    .rxBlock(rxBlock), .txBlock(txBlock)
  );

  typedef struct packed {
    logic        rate;
    logic [31:0] rx;
    logic [31:0] tx;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b0, 32'h8000_0001, 32'h5A5A_A5A5},
    '{1'b0, 32'h1234_5678, 32'hF0F0_0F0F},
    '{1'b1, 32'hFF00_0000, 32'h00FF_FFFF},
    '{1'b1, 32'hFFFF_FFFF, 32'h0081_8001},
    '{1'b0, 32'h0000_0000, 32'hFFFF_FFFF}
  };

  // Model state per direction: 0 = receive, 1 = transmit
  int          mPos   [2];
  bit          mValid [2];
  bit          mRate  [2];
  logic [31:0] mShadow[2];
  logic [31:0] mLive  [2];

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic expOut(input int d);
    if (!mValid[d]) return 1'b0;
    if (mRate[d]) begin
      if (mPos[d] == 0) return 1'b0;
      return mLive[d][(mPos[d] - 1) / 8];
    end
    return mLive[d][mPos[d] / 8];
  endfunction

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      mPos[d] = 0; mValid[d] = 0; mRate[d] = 0; mShadow[d] = '0; mLive[d] = '0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] dat);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = dat;
    @(negedge clk);
    regWr = 1'b0;
    if (a >= 8'h2B && a <= 8'h2E) mShadow[0][(a - 8'h2B) * 8 +: 8] = dat;
    if (a >= 8'h22 && a <= 8'h25) mShadow[1][(a - 8'h22) * 8 +: 8] = dat;
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check8(tag, regRdData, exp);
  endtask

  task automatic modelStep(input int d, input bit sync);
    int last = mRate[d] ? 192 : 255;
    if (sync || (mValid[d] && mPos[d] == last)) begin
      mPos[d] = 0; mValid[d] = 1; mRate[d] = sysRate; mLive[d] = mShadow[d];
    end else if (mValid[d]) begin
      mPos[d]++;
    end
  endtask

  task automatic stepBit(input bit rxEn, input bit rxS, input bit txEn, input bit txS,
                         input string tag);
    @(negedge clk);
    rxBitEn = rxEn; rxFrameSync = rxS; txBitEn = txEn; txFrameSync = txS;
    @(negedge clk);
    rxBitEn = 0; rxFrameSync = 0; txBitEn = 0; txFrameSync = 0;
    if (rxEn) modelStep(0, rxS);
    if (txEn) modelStep(1, txS);
    check1({tag, " rx"}, rxBlock, expOut(0));
    check1({tag, " tx"}, txBlock, expOut(1));
  endtask

  task automatic runBits(input int n, input string tag);
    for (int i = 0; i < n; i++) stepBit(1, 0, 1, 0, tag);
  endtask

  task automatic rdAll(input string tag);
    for (int b = 0; b < 4; b++) begin
      rdCheck(tag, 8'(8'h2B + b), mShadow[0][b*8 +: 8]);
      rdCheck(tag, 8'(8'h22 + b), mShadow[1][b*8 +: 8]);
    end
  endtask

  initial begin
    rstN = 0; sysRate = 0; regWr = 0; regAddr = '0; regWrData = '0;
    rxBitEn = 0; rxFrameSync = 0; txBitEn = 0; txFrameSync = 0;
    modelReset();
    doReset();

    // R2 reset values, R7 no output before sync
    rdAll("R2 reset readback");
    rdCheck("R2 unmapped address", 8'h30, 8'h00);
    check1("R7 rx after reset", rxBlock, 1'b0);
    check1("R7 tx after reset", txBlock, 1'b0);
    runBits(20, "R7 no sync");
    for (int b = 0; b < 4; b++) begin
      wrReg(8'(8'h2B + b), 8'hFF);
      wrReg(8'(8'h22 + b), 8'hFF);
    end
    runBits(10, "R7 masks set, no sync");

    // Table of patterns: R1 mapping, R3 / R4 frame scan, R5 upper byte
    for (int v = 0; v < NV; v++) begin
      sysRate = VECS[v].rate;
      for (int b = 0; b < 4; b++) begin
        wrReg(8'(8'h2B + b), VECS[v].rx[b*8 +: 8]);
        wrReg(8'(8'h22 + b), VECS[v].tx[b*8 +: 8]);
      end
      rdAll("R1/R2 readback");
      stepBit(1, 1, 1, 1, "R1 sync");
      runBits(VECS[v].rate ? 193 : 256, VECS[v].rate ? "R4 R5 scan" : "R1 R3 scan");
    end

    // R5: fourth byte set alone in 24-channel mode keeps strobe low
    sysRate = 1;
    for (int b = 0; b < 3; b++) begin
      wrReg(8'(8'h2B + b), 8'h00);
      wrReg(8'(8'h22 + b), 8'h00);
    end
    wrReg(8'h2E, 8'hFF);
    wrReg(8'h25, 8'hFF);
    rdCheck("R5 upper byte stored", 8'h2E, 8'hFF);
    stepBit(1, 1, 1, 1, "R5 sync");
    runBits(200, "R5 upper cut");

    // R6: mid-frame write waits for the wrap
    sysRate = 0;
    wrReg(8'h2B, 8'h00);
    wrReg(8'h2E, 8'h00);
    stepBit(1, 1, 1, 1, "R6 sync");
    runBits(100, "R6 before write");
    wrReg(8'h2B, 8'hFF);
    wrReg(8'h2D, 8'hFF);
    check1("R6 rx unchanged after write", rxBlock, 1'b0);
    runBits(156, "R6 rest of frame");
    check1("R6 rx channel 1 live after wrap", rxBlock, 1'b1);
    runBits(100, "R6 next frame");

    // R8: flywheel and mid-frame resync
    runBits(520, "R8 flywheel");
    stepBit(1, 1, 1, 1, "R8 mid-frame sync");
    check1("R8 rx restarts at channel 1", rxBlock, 1'b1);
    runBits(30, "R8 after resync");

    // R9: rate change mid-frame takes effect at the boundary
    stepBit(1, 1, 1, 1, "R9 sync");
    runBits(50, "R9 start");
    sysRate = 1;
    runBits(300, "R9 rate change");
    sysRate = 0;
    runBits(300, "R9 rate back");

    // R10: directions tracked independently
    doReset();
    for (int b = 0; b < 4; b++) begin
      wrReg(8'(8'h2B + b), 8'hA5);
      wrReg(8'(8'h22 + b), 8'h3C);
    end
    stepBit(1, 1, 1, 0, "R10 rx only sync");
    runBits(60, "R10 tx unsynced");
    stepBit(1, 0, 1, 1, "R10 tx sync later");
    runBits(200, "R10 offset frames");
    for (int i = 0; i < 40; i++) stepBit(1, 0, 0, 0, "R10 tx enable idle");
    runBits(40, "R10 both running");

    // R2: reset in operation clears registers and outputs
    doReset();
    rdAll("R2 reset mid-run");
    check1("R7 rx after second reset", rxBlock, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule